// File: doc/BRIEF.md
# Transmit Frame Gate and Padder

This block sits on the transmit path between a packet source and the line. The source delivers byte-wide frames, with a start marker on the first byte and an end marker on the last, over a valid/ready handshake. The line side has no backpressure: every output byte is taken as it appears. A software enable lets whole frames through and holds them back only between frames, so a frame that has started always finishes. Frames that are not yet accepted wait at the input and are not lost.

When check-sequence insertion is on, the block appends a 4-byte CRC-32. When padding is also on, it first extends short frames with zero bytes to the 64-byte Ethernet minimum. A frame that runs past the configured maximum transfer length is cut at the limit, the rest of the input frame is discarded, and an error pulse is raised. Two saturating counters track sent frames and sent bytes, each with its own overflow pulse, and a frame-sent pulse marks each completed frame. A soft-reset command returns the whole block to its power-on state. The maximum length is a plain input. Integration normally ties it to 9250.

The controller is a state machine with five states. IDLE waits for a start byte. DATA forwards body bytes. PAD emits zero fill. CHECK emits the four CRC bytes. DISCARD swallows the tail of a truncated frame. The transitions are:
- IDLE→DATA: a start byte is accepted and it is not also the end byte.
- IDLE/DATA→PAD: the end byte arrives with padding and insertion on and the body below 60 bytes.
- IDLE/DATA→CHECK: the end byte arrives with insertion on, or the length limit is hit with insertion on.
- IDLE/DATA→IDLE: the end byte arrives with insertion off.
- DATA→DISCARD: the limit is hit with insertion off.
- PAD→CHECK: the body reaches 60 bytes.
- CHECK→IDLE: the last CRC byte goes out.
- CHECK→DISCARD: the last CRC byte goes out after a truncation.
- DISCARD→IDLE: the input end byte is consumed.

Top module: `tx_frame_gate`

## Requirements
- R1: While IDLE with `tx_enable`=0, `in_ready` is 0 and no frame starts. A waiting frame is emitted intact once `tx_enable` returns to 1.
- R2: Clearing `tx_enable` after a frame has started lets that frame complete, including pad and CRC bytes.
- R3: Bytes arriving in IDLE without `in_sop` are consumed (`in_ready`=1 when enabled) and produce no output.
- R4: With `fcs_enable`=0, the output frame equals the input frame byte for byte. `out_sop` is on the first byte and `out_eop` on the last. Each output byte appears one cycle after its input byte is accepted.
- R5: With `fcs_enable`=1, four bytes follow the body. They are the CRC-32 (reflected, polynomial 0xEDB88320, initial value all ones, result complemented) over body and pad bytes, sent least significant byte first, with `out_eop` on the fourth.
- R6: With `pad_enable`=1 and `fcs_enable`=1, a body shorter than 60 bytes is followed by zero bytes up to 60, so the frame is 64 bytes. With `fcs_enable`=0, `pad_enable` has no effect.
- R7: The body is limited to `max_len` bytes, minus 4 when `fcs_enable`=1. A frame that reaches the limit without its end byte is ended there (with CRC if enabled), its remaining input bytes are discarded, and `err_too_long` pulses for one cycle alongside the last body byte. `max_len` must be at least 64.
- R8: `byte_count` increments for every output byte (body, pad, CRC) and `frame_count` for every `out_eop`, but only for bytes emitted in a cycle in which `tx_enable`=1. Otherwise both hold.
- R9: Both counters saturate at all ones. `evt_byte_ovf` / `evt_frame_ovf` pulse in each cycle in which an increment is lost to saturation.
- R10: `evt_frame_sent` pulses together with `out_eop` when `tx_enable`=1.
- R11: A one-cycle `soft_rst` pulse drives `in_ready` low in the next cycle. One cycle later, counters, events and outputs are zero and the controller is IDLE.
- R12: After `rst_n` reset, the outputs, events and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft-reset command, one cycle |
| tx_enable | input | 1 | Transmit enable, acts at frame boundaries |
| fcs_enable | input | 1 | Append CRC-32 |
| pad_enable | input | 1 | Pad short frames (needs fcs_enable) |
| max_len | input | LEN_W | Maximum total transfer length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of frame |
| in_eop | input | 1 | Last byte of frame |
| in_ready | output | 1 | Input byte accepted this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First output byte of frame |
| out_eop | output | 1 | Last output byte of frame |
| frame_count | output | CNT_W | Saturating sent-frame counter |
| byte_count | output | CNT_W | Saturating sent-byte counter |
| evt_frame_sent | output | 1 | Frame completed pulse |
| evt_frame_ovf | output | 1 | Frame counter increment lost |
| evt_byte_ovf | output | 1 | Byte counter increment lost |
| err_too_long | output | 1 | Frame truncated pulse |

## Verification
The bound checker watches the per-cycle rules on every edge:
- no frame starts unless the enable was high;
- both counters stay frozen while disabled;
- a saturated counter stays saturated and a counter never decreases;
- every overflow pulse coincides with an all-ones counter;
- the frame-sent and truncation pulses line up with an output byte;
- the soft reset clears everything.

The bench's reference model shows what the checker cannot: exact byte content, the CRC values, pad length and truncation point, frames held back and later released intact, and stray bytes discarded.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAD,
        ST_CHECK,
        ST_DISCARD
    } gate_state_e;

    localparam int          MIN_BODY  = 60;
    localparam int          FCS_BYTES = 4;
    localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;

    // one byte step of the reflected CRC-32
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_sat_counter.sv
module tx_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= inc && (count == TOP);
            if (inc && (count != TOP)) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_crc32_unit.sv
module tx_crc32_unit
    import tx_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        feed,
    input  logic        start,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else if (clr) begin
            crc_q <= CRC_INIT;
        end else if (feed) begin
            crc_q <= crc32_step(start ? CRC_INIT : crc_q, din);
        end
    end

    assign fcs = ~crc_q;
endmodule

// File: rtl/tx_frame_gate.sv
module tx_frame_gate
    import tx_gate_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             tx_enable,
    input  logic             fcs_enable,
    input  logic             pad_enable,
    input  logic [LEN_W-1:0] max_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic [CNT_W-1:0] frame_count,
    output logic [CNT_W-1:0] byte_count,
    output logic             evt_frame_sent,
    output logic             evt_frame_ovf,
    output logic             evt_byte_ovf,
    output logic             err_too_long
);
    localparam int               NUM_CNT  = 2;
    localparam int               IDX_FR   = 0;
    localparam int               IDX_BY   = 1;
    localparam logic [LEN_W-1:0] BODY_MIN = LEN_W'(MIN_BODY);
    localparam logic [LEN_W-1:0] FCS_LEN  = LEN_W'(FCS_BYTES);

    gate_state_e      st, st_n;
    logic [LEN_W-1:0] len, len_n, data_limit;
    logic [1:0]       fidx, fidx_n;
    logic             drop_pend, drop_pend_n;
    logic             rst_hold;
    logic             take, first, trunc;
    logic             o_v, o_s, o_e;
    logic [7:0]       o_d;
    logic [31:0]      fcs_word;
    logic [NUM_CNT-1:0] cnt_inc, cnt_ovf;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    assign data_limit = max_len - (fcs_enable ? FCS_LEN : '0);

    // next state and next output
    always_comb begin
        st_n        = st;
        len_n       = len;
        fidx_n      = fidx;
        drop_pend_n = drop_pend;
        in_ready    = 1'b0;
        take        = 1'b0;
        first       = 1'b0;
        trunc       = 1'b0;
        o_v         = 1'b0;
        o_d         = 8'd0;
        o_s         = 1'b0;
        o_e         = 1'b0;
        unique case (st)
            ST_IDLE: begin
                in_ready = tx_enable && !rst_hold;
                if (in_valid && in_ready && in_sop) begin
                    take  = 1'b1;
                    first = 1'b1;
                end
            end
            ST_DATA: begin
                in_ready = !rst_hold;
                if (in_valid && in_ready) begin
                    take = 1'b1;
                end
            end
            ST_PAD: begin
                o_v   = 1'b1;
                len_n = len + 1'b1;
                if (len_n == BODY_MIN) begin
                    st_n = ST_CHECK;
                end
            end
            ST_CHECK: begin
                o_v    = 1'b1;
                o_d    = fcs_word[{fidx, 3'b000} +: 8];
                fidx_n = fidx + 1'b1;
                if (fidx == 2'd3) begin
                    o_e         = 1'b1;
                    st_n        = drop_pend ? ST_DISCARD : ST_IDLE;
                    drop_pend_n = 1'b0;
                end
            end
            ST_DISCARD: begin
                in_ready = !rst_hold;
                if (in_valid && in_ready && in_eop) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (take) begin
            o_v   = 1'b1;
            o_d   = in_data;
            o_s   = first;
            len_n = first ? LEN_W'(1) : len + 1'b1;
            if (in_eop) begin
                if (fcs_enable) begin
                    st_n = (pad_enable && (len_n < BODY_MIN)) ? ST_PAD : ST_CHECK;
                end else begin
                    o_e  = 1'b1;
                    st_n = ST_IDLE;
                end
            end else if (len_n == data_limit) begin
                trunc = 1'b1;
                if (fcs_enable) begin
                    st_n        = ST_CHECK;
                    drop_pend_n = 1'b1;
                end else begin
                    o_e  = 1'b1;
                    st_n = ST_DISCARD;
                end
            end else begin
                st_n = ST_DATA;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            len       <= '0;
            fidx      <= '0;
            drop_pend <= 1'b0;
            rst_hold  <= 1'b0;
        end else begin
            rst_hold <= soft_rst;
            if (rst_hold) begin
                st        <= ST_IDLE;
                len       <= '0;
                fidx      <= '0;
                drop_pend <= 1'b0;
            end else begin
                st        <= st_n;
                len       <= len_n;
                fidx      <= fidx_n;
                drop_pend <= drop_pend_n;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_data       <= 8'd0;
            out_sop        <= 1'b0;
            out_eop        <= 1'b0;
            evt_frame_sent <= 1'b0;
            err_too_long   <= 1'b0;
        end else if (rst_hold) begin
            out_valid      <= 1'b0;
            out_data       <= 8'd0;
            out_sop        <= 1'b0;
            out_eop        <= 1'b0;
            evt_frame_sent <= 1'b0;
            err_too_long   <= 1'b0;
        end else begin
            out_valid      <= o_v;
            out_data       <= o_d;
            out_sop        <= o_s;
            out_eop        <= o_e;
            evt_frame_sent <= o_e && tx_enable;
            err_too_long   <= trunc;
        end
    end

    tx_crc32_unit u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rst_hold),
        .feed  (o_v && !o_e && (st != ST_CHECK)),
        .start (first),
        .din   (o_d),
        .fcs   (fcs_word)
    );

    assign cnt_inc[IDX_FR] = o_e && tx_enable;
    assign cnt_inc[IDX_BY] = o_v && tx_enable;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        tx_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (rst_hold),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g]),
            .ovf   (cnt_ovf[g])
        );
    end

    assign frame_count   = cnt_val[IDX_FR];
    assign byte_count    = cnt_val[IDX_BY];
    assign evt_frame_ovf = cnt_ovf[IDX_FR];
    assign evt_byte_ovf  = cnt_ovf[IDX_BY];
endmodule

// File: rtl/tx_frame_gate_sva.sv
module tx_frame_gate_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_enable,
    input logic             rst_hold,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic [CNT_W-1:0] frame_count,
    input logic [CNT_W-1:0] byte_count,
    input logic             evt_frame_sent,
    input logic             evt_frame_ovf,
    input logic             evt_byte_ovf,
    input logic             err_too_long
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    assert_start_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> $past(tx_enable));

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tx_enable) && !$past(rst_hold)) |-> ($stable(byte_count) && $stable(frame_count)));

    assert_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_hold |=> (byte_count >= $past(byte_count)) && (frame_count >= $past(frame_count)));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count == TOP && !rst_hold) |=> frame_count == TOP);

    assert_byte_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_byte_ovf |-> byte_count == TOP);

    assert_frame_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame_ovf |-> frame_count == TOP);

    assert_sent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame_sent |-> (out_valid && out_eop));

    assert_trunc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_too_long |-> out_valid);

    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_hold) |-> (frame_count == '0 && byte_count == '0 && !out_valid));
endmodule

bind tx_frame_gate tx_frame_gate_sva #(.CNT_W(CNT_W)) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_enable      (tx_enable),
    .rst_hold       (rst_hold),
    .out_valid      (out_valid),
    .out_sop        (out_sop),
    .out_eop        (out_eop),
    .frame_count    (frame_count),
    .byte_count     (byte_count),
    .evt_frame_sent (evt_frame_sent),
    .evt_frame_ovf  (evt_frame_ovf),
    .evt_byte_ovf   (evt_byte_ovf),
    .err_too_long   (err_too_long)
);

// File: tb/tx_frame_gate_bench.sv
module tx_frame_gate_bench;
    localparam int CNT_W = 8;
    localparam int LEN_W = 14;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic             tx_enable = 1'b1;
    logic             fcs_enable = 1'b0;
    logic             pad_enable = 1'b0;
    logic [LEN_W-1:0] max_len = LEN_W'(9250);
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = 8'd0;
    logic             in_sop = 1'b0;
    logic             in_eop = 1'b0;
    logic             in_ready;
    logic             out_valid, out_sop, out_eop;
    logic [7:0]       out_data;
    logic [CNT_W-1:0] frame_count, byte_count;
    logic             evt_frame_sent, evt_frame_ovf, evt_byte_ovf, err_too_long;

    always #5 clk = ~clk;

    tx_frame_gate #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_tx_frame_gate (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_enable(tx_enable),
        .fcs_enable(fcs_enable), .pad_enable(pad_enable), .max_len(max_len),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .frame_count(frame_count),
        .byte_count(byte_count), .evt_frame_sent(evt_frame_sent),
        .evt_frame_ovf(evt_frame_ovf), .evt_byte_ovf(evt_byte_ovf),
        .err_too_long(err_too_long)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] src_q [$];
    logic [9:0] exp_q [$];
    int  m_fr = 0, m_by = 0;
    int  n_err = 0, exp_err = 0, n_fovf = 0, n_bovf = 0;
    bit  run = 1'b0;
    logic acc = 1'b0, en_at = 1'b0, hold_m = 1'b0, clr_seen = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // queue an input frame and its expected output
    task automatic send_frame(input int n, input int seed);
        int limit = int'(max_len) - (fcs_enable ? 4 : 0);
        int body  = (n > limit) ? limit : n;
        logic [31:0] c = 32'hFFFFFFFF;
        logic [7:0] b;
        if (n > limit) exp_err++;
        for (int i = 0; i < n; i++) begin
            b = 8'((seed + i * 7) & 255);
            src_q.push_back({i == 0, i == n - 1, b});
        end
        for (int i = 0; i < body; i++) begin
            b = 8'((seed + i * 7) & 255);
            exp_q.push_back({i == 0, (!fcs_enable && i == body - 1), b});
            c = crc_ref(c, b);
        end
        if (fcs_enable) begin
            if (pad_enable) begin
                for (int i = body; i < 60; i++) begin
                    exp_q.push_back(10'd0);
                    c = crc_ref(c, 8'd0);
                end
            end
            c = ~c;
            for (int k = 0; k < 4; k++) exp_q.push_back({1'b0, k == 3, c[k*8 +: 8]});
        end
    endtask

    task automatic drain;
        while (src_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) begin
        acc      <= in_valid && in_ready;
        en_at    <= tx_enable;
        clr_seen <= hold_m;
        hold_m   <= soft_rst;
    end

    // source driver
    always @(negedge clk) begin
        if (acc && src_q.size() != 0) void'(src_q.pop_front());
        if (src_q.size() != 0) begin
            in_valid = 1'b1;
            {in_sop, in_eop, in_data} = src_q[0];
        end else begin
            in_valid = 1'b0;
            in_sop = 1'b0;
            in_eop = 1'b0;
        end
    end

    // reference model compared on every clock
    always @(negedge clk) begin
        if (rst_n && run) begin
            logic e_bo, e_fo, e_fs;
            logic [9:0] e;
            e_bo = 1'b0; e_fo = 1'b0; e_fs = 1'b0;
            if (clr_seen) begin
                m_fr = 0; m_by = 0;
            end else if (out_valid && en_at) begin
                if (m_by == MAXC) e_bo = 1'b1; else m_by++;
                if (out_eop) begin
                    e_fs = 1'b1;
                    if (m_fr == MAXC) e_fo = 1'b1; else m_fr++;
                end
            end
            if (out_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected output byte", out_data, -1);
                else begin
                    e = exp_q.pop_front();
                    chk({out_sop, out_eop, out_data} == e, "R4 R5 R6 R7 stream byte",
                        {out_sop, out_eop, out_data}, e);
                end
            end
            chk(int'(byte_count) == m_by, "R8 byte_count", byte_count, m_by);
            chk(int'(frame_count) == m_fr, "R8 frame_count", frame_count, m_fr);
            chk(evt_byte_ovf == e_bo && evt_frame_ovf == e_fo, "R9 overflow events",
                {evt_byte_ovf, evt_frame_ovf}, {e_bo, e_fo});
            chk(evt_frame_sent == e_fs, "R10 frame sent", evt_frame_sent, e_fs);
            if (err_too_long) n_err++;
            if (evt_frame_ovf) n_fovf++;
            if (evt_byte_ovf) n_bovf++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!out_valid && frame_count == 0 && byte_count == 0 && !evt_frame_sent && !err_too_long,
            "R12 reset state", {out_valid, frame_count, byte_count}, 0);
        run = 1'b1;

        // R4 plain pass-through
        send_frame(20, 3);
        drain();
        chk(frame_count == 1 && byte_count == 20, "R8 counts after first frame", byte_count, 20);
        send_frame(1, 200);
        drain();

        // R5 CRC append
        fcs_enable = 1'b1;
        send_frame(70, 11);
        drain();

        // R6 padding, short, single-byte and exact-size frames
        pad_enable = 1'b1;
        send_frame(10, 40);
        send_frame(1, 9);
        send_frame(60, 77);
        drain();
        // R6 pad without fcs has no effect
        fcs_enable = 1'b0;
        send_frame(10, 5);
        drain();

        // R7 truncation with and without CRC
        fcs_enable = 1'b1; pad_enable = 1'b0; max_len = LEN_W'(80);
        send_frame(100, 13);
        drain();
        fcs_enable = 1'b0; max_len = LEN_W'(70);
        send_frame(90, 21);
        send_frame(70, 22);
        drain();
        chk(n_err == exp_err && exp_err == 2, "R7 truncation pulses", n_err, 2);
        max_len = LEN_W'(9250);

        // R3 stray bytes without start marker
        src_q.push_back({2'b00, 8'hAA});
        src_q.push_back({2'b01, 8'hBB});
        send_frame(5, 50);
        drain();

        // R1 held back while disabled
        tx_enable = 1'b0;
        @(negedge clk);
        send_frame(12, 60);
        repeat (30) @(negedge clk);
        chk(!in_ready, "R1 in_ready low while disabled", in_ready, 0);
        chk(src_q.size() == 12, "R1 frame held not dropped", src_q.size(), 12);
        tx_enable = 1'b1;
        drain();

        // R2 disable mid-frame, frame completes
        fcs_enable = 1'b1; pad_enable = 1'b1;
        send_frame(40, 90);
        repeat (15) @(negedge clk);
        tx_enable = 1'b0;
        drain();
        chk(exp_q.size() == 0, "R2 frame completed after disable", exp_q.size(), 0);
        tx_enable = 1'b1;

        // R11 soft reset
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(!in_ready, "R11 in_ready low during reset", in_ready, 0);
        @(negedge clk);
        chk(frame_count == 0 && byte_count == 0, "R11 counters cleared", byte_count, 0);
        repeat (2) @(negedge clk);

        // R9 saturation of both counters
        fcs_enable = 1'b0; pad_enable = 1'b0;
        n_fovf = 0; n_bovf = 0;
        for (int f = 0; f < 260; f++) send_frame(1, f);
        drain();
        chk(int'(frame_count) == MAXC && int'(byte_count) == MAXC, "R9 saturated counts", frame_count, MAXC);
        chk(n_fovf == 5 && n_bovf == 5, "R9 overflow pulse count", n_fovf, 5);

        chk(exp_q.size() == 0 && src_q.size() == 0, "R4 all traffic consumed", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule